// File: doc/BRIEF.md
# Debug Port Access Gate

This block decides, every clock, whether the on-chip debug access port and the boundary test access port may be reached from outside the chip. It combines a one-time-programmable chain-kill fuse, a software control word (chain kill bit, three-bit debug enable field, chain mode select), a flag that says the programmable logic has been configured, and a key-checked unlock strobe. From these it produces registered enables for each port and a routing select for the chain topology.

In cascade mode both ports sit on the fabric-side JTAG pins. In independent mode the test port stays on those pins and the debug port is steered to the alternate extended-I/O JTAG path. An unlock attempt with the wrong key locks the debug port out and raises a sticky illegal-access flag. Only a power-on reset clears that flag. A blown fuse keeps both ports off no matter how software or reset behave.

Top module: `dap_gate_ctrl`

## Requirements
- R1: While `fuse_chain_dis_i` is 1, `dbg_en_o` and `tap_en_o` are 0 from the next rising edge on, for every software setting and across power-on reset.
- R2: `st_fuse_o` equals `fuse_chain_dis_i` combinationally at all times, including while `rst_ni` is low.
- R3: A cycle with `unlock_stb_i`=1 and `unlock_key_i` different from parameter `UNLOCK_KEY` sets `st_illegal_o` at that edge. It stays 1 until `rst_ni` goes low. A later correct key does not clear it.
- R4: While the illegal-key lockout is set, `dbg_en_o` is 0, starting at the same edge that sets `st_illegal_o`. The lockout has no effect on `tap_en_o`.
- R5: When `sw_chain_dis_i` is 1, both enables are 0 at the next edge.
- R6: `dbg_en_o` can be 1 only when `sw_dbg_en_i` equals 3'b111, in either chain mode.
- R7: In cascade mode (`sw_mode_indep_i`=0), `tap_en_o` also requires `sw_dbg_en_i`=3'b111 and ignores `pl_cfg_done_i`. In this mode `route_indep_o` is 0 (both ports on the fabric pins).
- R8: In independent mode (`sw_mode_indep_i`=1), `tap_en_o` requires `pl_cfg_done_i`=1 and ignores `sw_dbg_en_i`. In this mode `route_indep_o` is 1 (debug port on the alternate path).
- R9: A strobe carrying the correct key sets `st_unlocked_o` at that edge. It stays 1 until power-on reset.
- R10: While `rst_ni` is low, `dbg_en_o`, `tap_en_o`, `route_indep_o`, `st_illegal_o` and `st_unlocked_o` are 0.
- R11: Every enable, route and sticky output is registered: an input change shows at the first rising edge after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Power-on reset, active low, asynchronous |
| fuse_chain_dis_i | input | 1 | Chain-kill fuse state |
| sw_chain_dis_i | input | 1 | Software chain kill |
| sw_dbg_en_i | input | 3 | Debug enable field; 3'b111 enables |
| sw_mode_indep_i | input | 1 | 0 cascade, 1 independent |
| pl_cfg_done_i | input | 1 | Programmable logic configured |
| unlock_stb_i | input | 1 | Unlock attempt strobe |
| unlock_key_i | input | 32 | Key carried by the strobe |
| dbg_en_o | output | 1 | Debug access port enable |
| tap_en_o | output | 1 | Test access port enable |
| route_indep_o | output | 1 | 1: debug port on alternate path |
| st_fuse_o | output | 1 | Fuse mirror status |
| st_illegal_o | output | 1 | Sticky wrong-key status |
| st_unlocked_o | output | 1 | Sticky correct-key status |

## Verification
The enable rules are driven through a table of control-word patterns. The table separates cascade from independent mode, full from partial debug-enable fields, and configured from unconfigured logic. Each row shows which of the inputs actually gate each port. All 32 register combinations are then applied with the fuse blown, before and after a reset, to show the fuse dominates. Key sequences follow: wrong then right without reset, then reset, then right alone. They show that the lockout is sticky, that it touches only the debug port, and that only reset clears it.

// File: rtl/dap_gate_pkg.sv
package dap_gate_pkg;
  localparam int unsigned DBG_FIELD_W = 3;
  localparam logic [DBG_FIELD_W-1:0] DBG_FIELD_ON = '1;
  typedef enum logic {MODE_CASCADE = 1'b0, MODE_INDEP = 1'b1} chain_mode_e;
endpackage

// File: rtl/dap_gate_lock.sv
module dap_gate_lock #(
  parameter int unsigned KEY_W = 32,
  parameter logic [KEY_W-1:0] UNLOCK_KEY = 32'hA5C3_5A3C
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             stb_i,
  input  logic [KEY_W-1:0] key_i,
  output logic             lock_nx_o,
  output logic             illegal_q_o,
  output logic             unlocked_q_o
);
  logic key_ok, illegal_q, unlocked_q;

  assign key_ok    = (key_i == UNLOCK_KEY);
  // lockout only sets; a good key never clears it
  assign lock_nx_o = illegal_q | (stb_i & ~key_ok);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      illegal_q  <= 1'b0;
      unlocked_q <= 1'b0;
    end else begin
      illegal_q  <= lock_nx_o;
      unlocked_q <= unlocked_q | (stb_i & key_ok);
    end
  end

  assign illegal_q_o  = illegal_q;
  assign unlocked_q_o = unlocked_q;

  AST_ILLEGAL_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_q |=> illegal_q); // R3
  AST_UNLOCK_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    unlocked_q |=> unlocked_q); // R9
  AST_BAD_KEY_LOCKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stb_i && !key_ok) |=> illegal_q); // R3
endmodule

// File: rtl/dap_gate_decode.sv
module dap_gate_decode
  import dap_gate_pkg::*;
(
  input  logic                   fuse_i,
  input  logic                   sw_dis_i,
  input  logic [DBG_FIELD_W-1:0] field_i,
  input  chain_mode_e            mode_i,
  input  logic                   cfg_done_i,
  input  logic                   lock_i,
  output logic                   dbg_nx_o,
  output logic                   tap_nx_o,
  output logic                   route_nx_o
);
  logic chain_ok, field_on;

  assign chain_ok = ~fuse_i & ~sw_dis_i;
  assign field_on = (field_i == DBG_FIELD_ON);

  always_comb begin
    dbg_nx_o   = chain_ok & field_on & ~lock_i;
    route_nx_o = (mode_i == MODE_INDEP);
    unique case (mode_i)
      MODE_CASCADE: tap_nx_o = chain_ok & field_on;
      MODE_INDEP:   tap_nx_o = chain_ok & cfg_done_i;
      default:      tap_nx_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/dap_gate_ctrl.sv
module dap_gate_ctrl
  import dap_gate_pkg::*;
#(
  parameter int unsigned KEY_W = 32,
  parameter logic [KEY_W-1:0] UNLOCK_KEY = 32'hA5C3_5A3C
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   fuse_chain_dis_i,
  input  logic                   sw_chain_dis_i,
  input  logic [DBG_FIELD_W-1:0] sw_dbg_en_i,
  input  logic                   sw_mode_indep_i,
  input  logic                   pl_cfg_done_i,
  input  logic                   unlock_stb_i,
  input  logic [KEY_W-1:0]       unlock_key_i,
  output logic                   dbg_en_o,
  output logic                   tap_en_o,
  output logic                   route_indep_o,
  output logic                   st_fuse_o,
  output logic                   st_illegal_o,
  output logic                   st_unlocked_o
);
  logic lock_nx, dbg_nx, tap_nx, route_nx;
  logic dbg_q, tap_q, route_q;
  chain_mode_e mode;

  assign mode = chain_mode_e'(sw_mode_indep_i);

  dap_gate_lock #(.KEY_W(KEY_W), .UNLOCK_KEY(UNLOCK_KEY)) u_lock (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .stb_i        (unlock_stb_i),
    .key_i        (unlock_key_i),
    .lock_nx_o    (lock_nx),
    .illegal_q_o  (st_illegal_o),
    .unlocked_q_o (st_unlocked_o)
  );

  dap_gate_decode u_dec (
    .fuse_i     (fuse_chain_dis_i),
    .sw_dis_i   (sw_chain_dis_i),
    .field_i    (sw_dbg_en_i),
    .mode_i     (mode),
    .cfg_done_i (pl_cfg_done_i),
    .lock_i     (lock_nx),
    .dbg_nx_o   (dbg_nx),
    .tap_nx_o   (tap_nx),
    .route_nx_o (route_nx)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dbg_q   <= 1'b0;
      tap_q   <= 1'b0;
      route_q <= 1'b0;
    end else begin
      dbg_q   <= dbg_nx;
      tap_q   <= tap_nx;
      route_q <= route_nx;
    end
  end

  assign dbg_en_o      = dbg_q;
  assign tap_en_o      = tap_q;
  assign route_indep_o = route_q;
  assign st_fuse_o     = fuse_chain_dis_i;

  AST_FUSE_KILLS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fuse_chain_dis_i |=> (!dbg_en_o && !tap_en_o)); // R1
  AST_LOCK_NO_DBG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_illegal_o |-> !dbg_en_o); // R4
  AST_SW_DIS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sw_chain_dis_i |=> (!dbg_en_o && !tap_en_o)); // R5
  AST_DBG_FIELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sw_dbg_en_i != DBG_FIELD_ON) |=> !dbg_en_o); // R6
  AST_INDEP_CFG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sw_mode_indep_i && !pl_cfg_done_i) |=> (!tap_en_o && route_indep_o)); // R8
  AST_CASC_ROUTE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sw_mode_indep_i |=> !route_indep_o); // R7
endmodule

// File: tb/sim_dap_gate_ctrl.sv
`timescale 1ns/1ps
module sim_dap_gate_ctrl;
  localparam logic [31:0] KEY = 32'hA5C3_5A3C;
  // {fuse, sw_dis, field[2:0], indep, cfg, exp_dbg, exp_tap, exp_route}
  localparam int NV = 8;
  localparam logic [9:0] VEC [NV] = '{
    10'b0_0_111_0_0_110,  // R7 cascade, cfg ignored
    10'b0_0_110_0_1_000,  // R6 R7 partial field
    10'b0_0_111_1_0_101,  // R8 unconfigured
    10'b0_0_000_1_1_011,  // R8 field ignored for tap
    10'b0_0_111_1_1_111,  // R8
    10'b0_1_111_0_1_000,  // R5
    10'b0_1_111_1_1_001,  // R5
    10'b0_0_011_0_1_000   // R6
  };

  logic clk = 0, rst_n = 0;
  logic fuse = 0, sw_dis = 0, indep = 0, cfg = 0, stb = 0;
  logic [2:0] field = 0;
  logic [31:0] key = 0;
  logic dbg_en, tap_en, route, st_fuse, st_ill, st_unl;
  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  dap_gate_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_n), .fuse_chain_dis_i(fuse), .sw_chain_dis_i(sw_dis),
    .sw_dbg_en_i(field), .sw_mode_indep_i(indep), .pl_cfg_done_i(cfg),
    .unlock_stb_i(stb), .unlock_key_i(key), .dbg_en_o(dbg_en), .tap_en_o(tap_en),
    .route_indep_o(route), .st_fuse_o(st_fuse), .st_illegal_o(st_ill),
    .st_unlocked_o(st_unl)
  );

  task automatic chk(input string req, input logic [5:0] act, input logic [5:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: act=%b exp=%b", req, act, exp);
    end
  endtask

  // outputs packed {dbg, tap, route, fuse, illegal, unlocked}
  function automatic logic [5:0] outs();
    return {dbg_en, tap_en, route, st_fuse, st_ill, st_unl};
  endfunction

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic strobe(input logic [31:0] k);
    stb = 1; key = k;
    step();
    stb = 0; key = 0;
  endtask

  initial begin
    #8_000_000;
    fails++;
    $display("FAIL watchdog: act=timeout exp=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R10 reset state", outs(), 6'b000000);
    fuse = 1; #1;
    chk("R2 mirror in reset", outs(), 6'b000100);
    fuse = 0; #1;
    rst_n = 1;
    step();

    foreach (VEC[i]) begin
      {fuse, sw_dis, field, indep, cfg} = VEC[i][9:3];
      step();
      chk($sformatf("R11 vec%0d", i), outs(), {VEC[i][2:0], 3'b000});
    end

    // R1: fuse blown, every software combination, then through reset
    fuse = 1;
    for (int c = 0; c < 32; c++) begin
      {sw_dis, field, indep} = c[4:0];
      cfg = 1;
      step();
      chk("R1 fuse kills", {outs()[5:4], outs()[2]}, {2'b00, 1'b1});
    end
    sw_dis = 0; field = 3'b111; indep = 0;
    rst_n = 0; step(); rst_n = 1; step(); step();
    chk("R1 fuse after reset", outs(), 6'b000100);
    fuse = 0; step();
    chk("R7 fuse clear", outs(), 6'b110000);

    // R3 R4: wrong key, then correct key without reset
    strobe(~KEY);
    chk("R3 R4 wrong key", outs(), 6'b010010);
    step();
    chk("R3 sticky", outs(), 6'b010010);
    strobe(KEY);
    chk("R3 R9 good key no clear", outs(), 6'b010011);
    indep = 1; cfg = 1; step();
    chk("R4 tap unaffected indep", outs(), 6'b011011);
    indep = 0;

    // power-on reset clears lockout
    rst_n = 0; #1;
    chk("R10 reset clears", outs(), 6'b000000);
    step(); rst_n = 1; step();
    chk("R3 cleared by reset", outs(), 6'b110000);
    strobe(KEY);
    chk("R9 good key", outs(), 6'b110001);
    step();
    chk("R9 sticky", outs(), 6'b110001);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule